// File: doc/BRIEF.md
# Crosspoint Routing and Power Control

This block is the digital control core of a four-lane by four-lane non-blocking crosspoint. Each output lane takes one of the four input lanes, chosen by a 2-bit route code. An input may feed any number of outputs at the same time. The route codes and the power settings come from one of two sources. In pin mode they come from a packed vector of external strap pins. In bus mode they come from register fields that a separate management-bus slave holds and presents as plain signals.

From the active settings the block works out a receiver-enable flag for each input lane and a driver-enable flag for each output lane. It registers the flags and the route map on the system clock. It passes single-bit stand-ins for the differential lanes through a combinational multiplexer, and it masks each input's signal-present flag with that input's receiver enable. The analog receivers, drivers and signal detectors sit outside the block. The global power rule differs by mode: in pin mode the power pin alone decides, and in bus mode the power pin and a soft power-up bit are ORed.

Top module: `xbar_route_top`

## Requirements
- R1: Output n carries input lane `laneIn[k]`, where k is output n's 2-bit route code: 00 selects lane 0, 01 lane 1, 10 lane 2 and 11 lane 3.
- R2: One input lane can be routed to two, three or all four outputs at once, and every such output carries that lane's value.
- R3: With `busMode`=0, output n's route code is `pinSel[2n+1:2n]`. With `busMode`=1, it is `cfgSel[2n+1:2n]` (bits [1:0] for output 0, up to [7:6] for output 3).
- R4: With `busMode`=0, the block is powered up exactly when `pinPowerUp`=1.
- R5: With `busMode`=1, the block is powered up when `pinPowerUp`=1 or `softPowerUp`=1, and powered down only when both are 0.
- R6: In bus mode while powered up, `drvEn[n]` equals `outEnable[n]`.
- R7: While powered up, `rxEn[i]`=1 exactly when some output's route code selects input i, or when monitoring is on (`busMode`=1 and `monEnable`=1).
- R8: While powered down, `drvEn` and `laneOut` are all 0. `rxEn` is all ones if monitoring is on and all zeros otherwise.
- R9: In pin mode, `outEnable` and `monEnable` have no effect: when powered up all four drivers are enabled and only routed inputs are received.
- R10: `sigStatus[i]` equals `sigValid[i]` (1 = valid signal, 0 = open or faulted) when `rxEn[i]`=1, and is 0 otherwise. A disabled output drives 0.
- R11: While `rstN`=0, `drvEn`, `rxEn`, `laneOut` and `sigStatus` are all 0.
- R12: A change of mode, route or power inputs shows on `drvEn`, `rxEn` and the routing one rising clock edge later. A change on `laneIn` reaches `laneOut` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busMode | input | 1 | 0 = settings from pins, 1 = settings from registers |
| pinPowerUp | input | 1 | Power pin, 1 = powered up |
| pinSel | input | 8 | Strap pin route codes, 2 bits per output |
| cfgSel | input | 8 | Register route codes, 2 bits per output |
| outEnable | input | 4 | Register per-output driver enables |
| monEnable | input | 1 | Register bit that keeps every receiver and monitor on |
| softPowerUp | input | 1 | Register soft power-up bit |
| laneIn | input | 4 | Digital stand-ins for the input lanes |
| sigValid | input | 4 | Signal-present flags from the input detectors |
| laneOut | output | 4 | Routed output lanes |
| drvEn | output | 4 | Per-output driver enables |
| rxEn | output | 4 | Per-input receiver enables |
| sigStatus | output | 4 | Gated per-input signal status |

## Verification
The bench builds the block with the package defaults: four inputs, four outputs and 2-bit route codes. At this size every route code on every output, full broadcast from one lane, and every combination of power pin, soft power-up and monitoring bit can be reached directly. Each setting is checked one edge after it is applied, against a model built from the requirements. Two direct probes check the one-edge control latency and the clock-free data path.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  parameter int XB_IN  = 4;
  parameter int XB_OUT = 4;
  localparam int SEL_W = $clog2(XB_IN);
  localparam int CFG_W = XB_OUT * SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  // strobes from control to datapath
  typedef struct packed {
    sel_t [XB_OUT-1:0] route;
    logic [XB_OUT-1:0] drvOn;
    logic [XB_IN-1:0]  rxOn;
  } xbar_ctrl_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              pinPowerUp,
  input  logic              softPowerUp,
  input  logic              monEnable,
  input  logic [CFG_W-1:0]  pinSel,
  input  logic [CFG_W-1:0]  cfgSel,
  input  logic [XB_OUT-1:0] outEnable,
  output xbar_ctrl_t        ctrlQ
);
  sel_t [XB_OUT-1:0] routeNext;
  logic [XB_IN-1:0]  usedIn;
  logic [XB_OUT-1:0] allowOut;
  logic              poweredUp;
  logic              monitorOn;
  xbar_ctrl_t        ctrlNext;

  // pick the route source by mode
  always_comb begin
    for (int n = 0; n < XB_OUT; n++) begin
      routeNext[n] = busMode ? cfgSel[n*SEL_W +: SEL_W] : pinSel[n*SEL_W +: SEL_W];
    end
  end

  // an input is in use if any output points at it
  for (genvar gi = 0; gi < XB_IN; gi++) begin : g_used
    always_comb begin
      usedIn[gi] = 1'b0;
      for (int n = 0; n < XB_OUT; n++) begin
        if (routeNext[n] == sel_t'(gi)) usedIn[gi] = 1'b1;
      end
    end
  end

  // global power and per-lane enables
  always_comb begin
    poweredUp = busMode ? (pinPowerUp | softPowerUp) : pinPowerUp;
    monitorOn = busMode & monEnable;
    allowOut  = busMode ? outEnable : {XB_OUT{1'b1}};

    ctrlNext.route = routeNext;
    ctrlNext.drvOn = poweredUp ? allowOut : '0;
    ctrlNext.rxOn  = poweredUp ? (usedIn | {XB_IN{monitorOn}}) : {XB_IN{monitorOn}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end
endmodule

// File: rtl/xbar_path.sv
module xbar_path
  import xbar_pkg::*;
(
  input  xbar_ctrl_t        ctrl,
  input  logic [XB_IN-1:0]  laneIn,
  input  logic [XB_IN-1:0]  sigValid,
  output logic [XB_OUT-1:0] laneOut,
  output logic [XB_IN-1:0]  sigStatus
);
  for (genvar go = 0; go < XB_OUT; go++) begin : g_mux
    assign laneOut[go] = ctrl.drvOn[go] & laneIn[ctrl.route[go]];
  end

  assign sigStatus = sigValid & ctrl.rxOn;
endmodule

// File: rtl/xbar_route_top.sv
module xbar_route_top
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              pinPowerUp,
  input  logic [CFG_W-1:0]  pinSel,
  input  logic [CFG_W-1:0]  cfgSel,
  input  logic [XB_OUT-1:0] outEnable,
  input  logic              monEnable,
  input  logic              softPowerUp,
  input  logic [XB_IN-1:0]  laneIn,
  input  logic [XB_IN-1:0]  sigValid,
  output logic [XB_OUT-1:0] laneOut,
  output logic [XB_OUT-1:0] drvEn,
  output logic [XB_IN-1:0]  rxEn,
  output logic [XB_IN-1:0]  sigStatus
);
  xbar_ctrl_t ctrlQ;

  xbar_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busMode    (busMode),
    .pinPowerUp (pinPowerUp),
    .softPowerUp(softPowerUp),
    .monEnable  (monEnable),
    .pinSel     (pinSel),
    .cfgSel     (cfgSel),
    .outEnable  (outEnable),
    .ctrlQ      (ctrlQ)
  );

  xbar_path u_path (
    .ctrl     (ctrlQ),
    .laneIn   (laneIn),
    .sigValid (sigValid),
    .laneOut  (laneOut),
    .sigStatus(sigStatus)
  );

  assign drvEn = ctrlQ.drvOn;
  assign rxEn  = ctrlQ.rxOn;
endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk
  import xbar_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busMode,
  input logic              pinPowerUp,
  input logic              softPowerUp,
  input logic              monEnable,
  input logic [XB_OUT-1:0] outEnable,
  input logic [XB_OUT-1:0] laneOut,
  input logic [XB_OUT-1:0] drvEn,
  input logic [XB_IN-1:0]  rxEn,
  input logic [XB_IN-1:0]  sigStatus
);
  // R8
  down_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pinPowerUp && (!busMode || !softPowerUp)) |=> (drvEn == '0));

  // R6
  bus_drive_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMode && (pinPowerUp || softPowerUp)) |=> (drvEn == $past(outEnable)));

  // R9
  pin_all_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busMode && pinPowerUp) |=> (drvEn == {XB_OUT{1'b1}}));

  // R7
  monitor_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMode && monEnable) |=> (rxEn == {XB_IN{1'b1}}));

  // R10
  status_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sigStatus & ~rxEn) == '0));

  // R10
  idle_out_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((laneOut & ~drvEn) == '0));
endmodule

bind xbar_route_top xbar_route_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busMode    (busMode),
  .pinPowerUp (pinPowerUp),
  .softPowerUp(softPowerUp),
  .monEnable  (monEnable),
  .outEnable  (outEnable),
  .laneOut    (laneOut),
  .drvEn      (drvEn),
  .rxEn       (rxEn),
  .sigStatus  (sigStatus)
);

// File: tb/sim_xbar_route_top.sv
`timescale 1ns/1ps
module sim_xbar_route_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busMode = 1'b0;
  logic       pinPowerUp = 1'b0;
  logic [7:0] pinSel = '0;
  logic [7:0] cfgSel = '0;
  logic [3:0] outEnable = '0;
  logic       monEnable = 1'b0;
  logic       softPowerUp = 1'b0;
  logic [3:0] laneIn = '0;
  logic [3:0] sigValid = '0;
  logic [3:0] laneOut, drvEn, rxEn, sigStatus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xbar_route_top u0 (
    .clk(clk), .rstN(rstN), .busMode(busMode), .pinPowerUp(pinPowerUp),
    .pinSel(pinSel), .cfgSel(cfgSel), .outEnable(outEnable), .monEnable(monEnable),
    .softPowerUp(softPowerUp), .laneIn(laneIn), .sigValid(sigValid),
    .laneOut(laneOut), .drvEn(drvEn), .rxEn(rxEn), .sigStatus(sigStatus)
  );

  typedef struct {
    logic [3:0] outV;
    logic [3:0] drvV;
    logic [3:0] rxV;
    logic [3:0] statV;
    string      tag;
  } item_t;

  item_t expQ[$];

  function automatic item_t predict(string tag);
    item_t e;
    logic up, mon;
    logic [3:0] allow, used;
    logic [1:0] code;
    up    = busMode ? (pinPowerUp | softPowerUp) : pinPowerUp;
    mon   = busMode & monEnable;
    allow = busMode ? outEnable : 4'b1111;
    used  = 4'b0000;
    e.outV = 4'b0000;
    for (int n = 0; n < 4; n++) begin
      code = busMode ? cfgSel[2*n +: 2] : pinSel[2*n +: 2];
      used[code] = 1'b1;
      e.outV[n] = (up && allow[n]) ? laneIn[code] : 1'b0;
    end
    e.drvV  = up ? allow : 4'b0000;
    e.rxV   = up ? (used | {4{mon}}) : {4{mon}};
    e.statV = e.rxV & sigValid;
    e.tag   = tag;
    return e;
  endfunction

  task automatic cmp(string tag, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: apply settings at the falling edge, push the prediction at the rising edge
  task automatic step(logic bm, logic pu, logic su, logic me, logic [7:0] ps,
                      logic [7:0] cs, logic [3:0] oe, logic [3:0] li,
                      logic [3:0] sv, string tag);
    @(negedge clk);
    busMode = bm; pinPowerUp = pu; softPowerUp = su; monEnable = me;
    pinSel = ps; cfgSel = cs; outEnable = oe; laneIn = li; sigValid = sv;
    @(posedge clk);
    expQ.push_back(predict(tag));
  endtask

  // monitor: compare settled outputs 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        cmp(e.tag, "laneOut", laneOut, e.outV);
        cmp(e.tag, "drvEn", drvEn, e.drvV);
        cmp(e.tag, "rxEn", rxEn, e.rxV);
        cmp(e.tag, "sigStatus", sigStatus, e.statV);
      end
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11 reset state with active-looking inputs
    busMode = 1'b1; softPowerUp = 1'b1; monEnable = 1'b1; outEnable = 4'hF;
    laneIn = 4'hF; sigValid = 4'hF;
    repeat (3) @(posedge clk);
    #5;
    cmp("R11", "drvEn", drvEn, 4'b0000);
    cmp("R11", "rxEn", rxEn, 4'b0000);
    cmp("R11", "laneOut", laneOut, 4'b0000);
    cmp("R11", "sigStatus", sigStatus, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R3 pin mode, straight routing, several lane patterns
    step(0, 1, 0, 0, 8'b11_10_01_00, 8'h00, 4'h0, 4'b1010, 4'b1111, "R1_R3_pin_straight");
    step(0, 1, 0, 0, 8'b11_10_01_00, 8'h00, 4'h0, 4'b0101, 4'b0110, "R1_pattern2");
    step(0, 1, 0, 0, 8'b00_01_10_11, 8'h00, 4'h0, 4'b0001, 4'b1001, "R1_reversed");
    step(0, 1, 0, 0, 8'b00_01_10_11, 8'h00, 4'h0, 4'b1110, 4'b1111, "R1_reversed2");
    // R2 broadcast
    step(0, 1, 0, 0, 8'b10_10_10_10, 8'h00, 4'h0, 4'b0100, 4'b1111, "R2_broadcast_all");
    step(0, 1, 0, 0, 8'b01_01_01_11, 8'h00, 4'h0, 4'b1010, 4'b1111, "R2_broadcast_three");
    // R4 R8 pin mode power down
    step(0, 0, 1, 1, 8'b11_10_01_00, 8'h00, 4'hF, 4'b1111, 4'b1111, "R4_R8_pin_down");
    // R9 pin mode ignores register enables and monitor bit
    step(0, 1, 0, 1, 8'b00_00_01_01, 8'h00, 4'h0, 4'b0011, 4'b1111, "R9_pin_ignores_regs");
    // R3 bus mode takes the register codes
    step(1, 1, 0, 0, 8'b00_00_00_00, 8'b01_11_00_10, 4'hF, 4'b1001, 4'b1111, "R3_bus_source");
    // R5 bus power combinations
    step(1, 0, 1, 0, 8'h00, 8'b11_10_01_00, 4'hF, 4'b0110, 4'b1111, "R5_soft_only");
    step(1, 1, 0, 0, 8'h00, 8'b11_10_01_00, 4'hF, 4'b1001, 4'b1111, "R5_pin_only");
    step(1, 0, 0, 0, 8'h00, 8'b11_10_01_00, 4'hF, 4'b1111, 4'b1111, "R5_R8_both_low");
    step(1, 0, 0, 1, 8'h00, 8'b11_10_01_00, 4'hF, 4'b1111, 4'b1010, "R8_down_monitor");
    // R6 per-output enables
    step(1, 1, 0, 0, 8'h00, 8'b11_10_01_00, 4'b0101, 4'b1111, 4'b1111, "R6_out_mask");
    step(1, 0, 1, 0, 8'h00, 8'b00_00_00_00, 4'b1010, 4'b0001, 4'b1111, "R6_mask_broadcast");
    // R7 receiver enables from routing or monitor
    step(1, 1, 0, 0, 8'h00, 8'b00_00_00_00, 4'hF, 4'b0001, 4'b1111, "R7_only_used");
    step(1, 1, 0, 1, 8'h00, 8'b00_00_00_00, 4'hF, 4'b0001, 4'b1111, "R7_monitor_all");
    // R10 status gating
    step(1, 1, 0, 0, 8'h00, 8'b11_11_01_01, 4'hF, 4'b0000, 4'b1011, "R10_gated");
    step(1, 1, 0, 1, 8'h00, 8'b11_11_01_01, 4'hF, 4'b0000, 4'b0110, "R10_monitored");

    // R12 one-edge latency of the control path
    step(1, 1, 0, 0, 8'h00, 8'b11_10_01_00, 4'hF, 4'b1111, 4'b1111, "R12_setup");
    @(negedge clk);
    outEnable = 4'b0000;
    #1;
    cmp("R12", "drvEn_before_edge", drvEn, 4'b1111);
    @(posedge clk);
    #5;
    cmp("R12", "drvEn_after_edge", drvEn, 4'b0000);
    // R12 data path needs no edge
    @(negedge clk);
    outEnable = 4'hF;
    @(posedge clk);
    #3;
    laneIn = 4'b0110;
    #1;
    cmp("R12", "laneOut_no_edge", laneOut, 4'b0110);

    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule